// File: doc/BRIEF.md
# Pipelined Fixed-Point Rational Coordinate Evaluator

This block computes one Cartesian coordinate of a joint position from seven fixed-point operands: two products are combined by subtraction, a third product is added, and the sum is divided by a separate divisor operand. It accepts a new operand set on every clock, and one result leaves per clock once the pipeline is full. A flag travelling with the data marks the cycles that carry a valid result.

The multiplier, subtractor and adder each sit in a fixed stage. Operands that are consumed late pass through delay lines, so every path through the pipeline has the same length. Division is a radix-2 restoring array with one register stage per quotient bit. The result is known to lie within plus or minus 1.5 length units, so the output word is only wide enough for that range. Any quotient outside it, or a division by zero, is clamped to the nearest bound and raises a sticky flag.

Top module: `rat_coord_pipe`

## Requirements
- R1: `out_valid_o` is high in exactly those cycles that follow, by 12 clock cycles, a cycle with `in_valid_i` high at a rising edge. It is never high otherwise.
- R2: A new operand set is accepted on every cycle. Back-to-back sets give results that are each correct and that leave in the order the sets entered.
- R3: All operands are signed 16-bit two's complement with 4 fraction bits. The result is (mul_a*mul_b - sub_a*sub_b + add_a*add_b) / div, given as signed 8-bit two's complement with 6 fraction bits (1 LSB = 1/64). It is truncated toward zero and lies within 1/16 of the exact value.
- R4: A quotient whose truncated magnitude exceeds 96 LSB (1.5) is clamped to +96 or -96, following the sign of the quotient. A magnitude of exactly 96 passes through unclamped and does not set the flag.
- R5: A zero divisor gives +96 when the numerator is zero or positive and -96 when it is negative. This counts as a clamp.
- R6: `ovf_o` rises on the same edge that delivers the first clamped result. It then stays high until reset, whatever later results are.
- R7: While `rst_ni` is low, `out_valid_o`, `coord_o` and `ovf_o` are all 0.
- R8: `coord_o` keeps the last result while `out_valid_o` is low. Operands presented with `in_valid_i` low produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operand set present this cycle |
| mul_a_i | input | 16 | First factor of the leading product |
| mul_b_i | input | 16 | Second factor of the leading product |
| sub_a_i | input | 16 | First factor of the subtracted product |
| sub_b_i | input | 16 | Second factor of the subtracted product |
| add_a_i | input | 16 | First factor of the added product |
| add_b_i | input | 16 | Second factor of the added product |
| div_i | input | 16 | Divisor |
| out_valid_o | output | 1 | Result present this cycle |
| coord_o | output | 8 | Coordinate, Q1.6 signed |
| ovf_o | output | 1 | Sticky clamp indicator |

## Verification
The output register can deliver the first clamped result, and so raise the sticky flag, in the same cycle that a fresh operand set enters and an earlier in-range result is still in flight. The bench provokes this by placing an out-of-range quotient, a zero divisor and an exact-bound quotient inside an unbroken stream of valid sets. For every result it judges the value, the 12-cycle distance from entry and the flag level, against a model flag that is updated in entry order. A long random back-to-back stream then mixes clamped and in-range results in adjacent cycles.

// File: rtl/rat_coord_pkg.sv
`timescale 1ns/1ps
package rat_coord_pkg;
  typedef struct packed {
    logic res_neg;   // sign of quotient
    logic num_neg;   // sign of numerator
    logic den_zero;  // divisor is zero
    logic big;       // quotient cannot fit the bit budget
  } div_side_t;

  function automatic int unsigned xw_of(int unsigned a, int unsigned b);
    return (a > b ? a : b) + 1;
  endfunction
endpackage

// File: rtl/rc_delay.sv
`timescale 1ns/1ps
module rc_delay #(
  parameter int unsigned W = 1,
  parameter int unsigned D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] tap_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < D; s++) tap_q[s] <= '0;
    end else begin
      tap_q[0] <= d_i;
      for (int s = 1; s < D; s++) tap_q[s] <= tap_q[s-1];
    end
  end

  assign q_o = tap_q[D-1];
endmodule

// File: rtl/rc_div_step.sv
`timescale 1ns/1ps
module rc_div_step
  import rat_coord_pkg::*;
#(
  parameter int unsigned XW  = 8,
  parameter int unsigned DW  = 4,
  parameter int unsigned QB  = 4,
  parameter int unsigned BIT = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XW-1:0] rem_i,
  input  logic [DW-1:0] den_i,
  input  logic [QB-1:0] quo_i,
  input  div_side_t     side_i,
  output logic [XW-1:0] rem_o,
  output logic [DW-1:0] den_o,
  output logic [QB-1:0] quo_o,
  output div_side_t     side_o
);
  logic [XW-1:0] trial;
  logic          fits;
  logic [QB-1:0] quo_n;

  always_comb begin
    trial      = XW'(den_i) << BIT;
    fits       = rem_i >= trial;
    quo_n      = quo_i;
    quo_n[BIT] = fits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_o  <= '0;
      den_o  <= '0;
      quo_o  <= '0;
      side_o <= '0;
    end else begin
      rem_o  <= fits ? rem_i - trial : rem_i;
      den_o  <= den_i;
      quo_o  <= quo_n;
      side_o <= side_i;
    end
  end
endmodule

// File: rtl/rc_div_pipe.sv
`timescale 1ns/1ps
// Sign/magnitude prep stage, then QB-1 restoring steps (bits QB-1..1).
// Bit 0 is resolved by the consumer.
module rc_div_pipe
  import rat_coord_pkg::*;
#(
  parameter int unsigned SW = 34,
  parameter int unsigned DW = 16,
  parameter int unsigned QB = 7,
  parameter int unsigned SH = 2,
  localparam int unsigned XW = xw_of(SW + SH, DW + QB)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [SW-1:0] num_i,
  input  logic signed [DW-1:0] den_i,
  output logic        [XW-1:0] rem_o,
  output logic        [DW-1:0] den_o,
  output logic        [QB-1:0] quo_o,
  output div_side_t            side_o
);
  logic [SW-1:0] num_mag;
  logic [DW-1:0] den_mag;
  logic [XW-1:0] num_ext, lim;
  div_side_t     side_n;

  always_comb begin
    num_mag         = num_i[SW-1] ? (~num_i + 1'b1) : num_i;
    den_mag         = den_i[DW-1] ? (~den_i + 1'b1) : den_i;
    num_ext         = XW'(num_mag) << SH;
    lim             = XW'(den_mag) << QB;
    side_n.res_neg  = num_i[SW-1] ^ den_i[DW-1];
    side_n.num_neg  = num_i[SW-1];
    side_n.den_zero = (den_mag == '0);
    side_n.big      = num_ext >= lim;
  end

  logic [XW-1:0] rem0_q;
  logic [DW-1:0] den0_q;
  div_side_t     side0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem0_q  <= '0;
      den0_q  <= '0;
      side0_q <= '0;
    end else begin
      rem0_q  <= num_ext;
      den0_q  <= den_mag;
      side0_q <= side_n;
    end
  end

  for (genvar i = 0; i < QB - 1; i++) begin : g_step
    logic [XW-1:0] rem_in, rem_out;
    logic [DW-1:0] den_in, den_out;
    logic [QB-1:0] quo_in, quo_out;
    div_side_t     side_in, side_out;

    if (i == 0) begin : g_src
      assign rem_in  = rem0_q;
      assign den_in  = den0_q;
      assign quo_in  = '0;
      assign side_in = side0_q;
    end else begin : g_src
      assign rem_in  = g_step[i-1].rem_out;
      assign den_in  = g_step[i-1].den_out;
      assign quo_in  = g_step[i-1].quo_out;
      assign side_in = g_step[i-1].side_out;
    end

    rc_div_step #(.XW(XW), .DW(DW), .QB(QB), .BIT(QB - 1 - i)) u_step (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rem_i (rem_in),
      .den_i (den_in),
      .quo_i (quo_in),
      .side_i(side_in),
      .rem_o (rem_out),
      .den_o (den_out),
      .quo_o (quo_out),
      .side_o(side_out)
    );
  end

  assign rem_o  = g_step[QB-2].rem_out;
  assign den_o  = g_step[QB-2].den_out;
  assign quo_o  = g_step[QB-2].quo_out;
  assign side_o = g_step[QB-2].side_out;
endmodule

// File: rtl/rat_coord_pipe.sv
`timescale 1ns/1ps
module rat_coord_pipe
  import rat_coord_pkg::*;
#(
  parameter int unsigned IN_W     = 16,
  parameter int unsigned IN_FRAC  = 4,
  parameter int unsigned OUT_W    = 8,
  parameter int unsigned OUT_FRAC = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  mul_a_i,
  input  logic signed [IN_W-1:0]  mul_b_i,
  input  logic signed [IN_W-1:0]  sub_a_i,
  input  logic signed [IN_W-1:0]  sub_b_i,
  input  logic signed [IN_W-1:0]  add_a_i,
  input  logic signed [IN_W-1:0]  add_b_i,
  input  logic signed [IN_W-1:0]  div_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] coord_o,
  output logic                    ovf_o
);
  localparam int unsigned PW    = 2 * IN_W;          // product, 2*IN_FRAC fraction bits
  localparam int unsigned DFW   = PW + 1;            // difference node
  localparam int unsigned SW    = PW + 2;            // sum node
  localparam int unsigned QB    = OUT_W - 1;         // quotient magnitude bits
  localparam int unsigned SH    = OUT_FRAC - IN_FRAC;
  localparam int unsigned XW    = xw_of(SW + SH, IN_W + QB);
  localparam int unsigned LAT   = QB + 5;
  localparam int unsigned LIMIT = 3 << (OUT_FRAC - 1); // 1.5 in output LSBs

  // stage 1: operand capture
  logic signed [IN_W-1:0] ma1, mb1, sa1, sb1, aa1, ab1, dv1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ma1 <= '0; mb1 <= '0; sa1 <= '0; sb1 <= '0;
      aa1 <= '0; ab1 <= '0; dv1 <= '0;
    end else begin
      ma1 <= mul_a_i; mb1 <= mul_b_i; sa1 <= sub_a_i; sb1 <= sub_b_i;
      aa1 <= add_a_i; ab1 <= add_b_i; dv1 <= div_i;
    end
  end

  // balancing delays: added-product factors by 1, divisor by 3
  logic [2*IN_W-1:0]      addf2;
  logic signed [IN_W-1:0] aa2, ab2, dv4;
  rc_delay #(.W(2 * IN_W), .D(1)) u_dly_add (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({aa1, ab1}), .q_o(addf2)
  );
  rc_delay #(.W(IN_W), .D(3)) u_dly_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dv1), .q_o(dv4)
  );
  assign aa2 = addf2[2*IN_W-1:IN_W];
  assign ab2 = addf2[IN_W-1:0];

  // stages 2..4
  logic signed [PW-1:0]  pm2, ps2, pa3;
  logic signed [DFW-1:0] df3;
  logic signed [SW-1:0]  sm4;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pm2 <= '0; ps2 <= '0; pa3 <= '0; df3 <= '0; sm4 <= '0;
    end else begin
      pm2 <= PW'(ma1) * PW'(mb1);
      ps2 <= PW'(sa1) * PW'(sb1);
      df3 <= DFW'(pm2) - DFW'(ps2);
      pa3 <= PW'(aa2) * PW'(ab2);
      sm4 <= SW'(df3) + SW'(pa3);
    end
  end

  // division
  logic [XW-1:0]   dv_rem;
  logic [IN_W-1:0] dv_den;
  logic [QB-1:0]   dv_quo;
  div_side_t       dv_side;
  rc_div_pipe #(.SW(SW), .DW(IN_W), .QB(QB), .SH(SH)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .num_i (sm4),
    .den_i (dv4),
    .rem_o (dv_rem),
    .den_o (dv_den),
    .quo_o (dv_quo),
    .side_o(dv_side)
  );

  logic v_pre;
  rc_delay #(.W(1), .D(LAT - 1)) u_dly_vld (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(in_valid_i), .q_o(v_pre)
  );

  // last quotient bit, clamp, sign
  logic             fits0, sat, sgn;
  logic [QB-1:0]    qf;
  logic [OUT_W-1:0] mag, res;
  always_comb begin
    fits0 = dv_rem >= XW'(dv_den);
    qf    = dv_quo | QB'(fits0);
    sat   = dv_side.den_zero | dv_side.big | (qf > QB'(LIMIT));
    sgn   = dv_side.den_zero ? dv_side.num_neg : dv_side.res_neg;
    mag   = sat ? OUT_W'(LIMIT) : OUT_W'(qf);
    res   = sgn ? (~mag + 1'b1) : mag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      coord_o     <= '0;
      ovf_o       <= 1'b0;
    end else begin
      out_valid_o <= v_pre;
      if (v_pre) begin
        coord_o <= res;
        ovf_o   <= ovf_o | sat;
      end
    end
  end
endmodule

// File: rtl/rat_coord_pipe_chk.sv
`timescale 1ns/1ps
module rat_coord_pipe_chk #(
  parameter int unsigned OUT_W    = 8,
  parameter int unsigned OUT_FRAC = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    out_valid_o,
  input logic signed [OUT_W-1:0] coord_o,
  input logic                    ovf_o
);
  localparam int LAT   = OUT_W + 4;
  localparam int LIMIT = 3 << (OUT_FRAC - 1);
  localparam int CW    = $clog2(LAT + 2) + 1;

  logic [CW-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CW'(in_valid_i) - CW'(out_valid_o);
  end

  a_r1_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(inflight_q) <= LAT);

  a_r1_no_orphan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> inflight_q != '0);

  a_r4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(coord_o) <= LIMIT && int'(coord_o) >= -LIMIT));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r6_rise_on_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (out_valid_o && (int'(coord_o) == LIMIT || int'(coord_o) == -LIMIT)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(coord_o));
endmodule

bind rat_coord_pipe rat_coord_pipe_chk #(.OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .coord_o    (coord_o),
  .ovf_o      (ovf_o)
);

// File: tb/rat_coord_pipe_test.sv
`timescale 1ns/1ps
module rat_coord_pipe_test;
  localparam int LAT = 12;
  localparam int LIM = 96;
  localparam int NV  = 12;
  // {mul_a, mul_b, sub_a, sub_b, add_a, add_b, div, expected}  (Q4 in, Q6 out)
  localparam int TV [NV][8] = '{
    '{ 16, 16,   0,  0, 0, 0,  16,  64},
    '{ 16,  8,   8,  8, 0, 0,  32,   8},
    '{-16, 16,   0,  0, 0, 0,  16, -64},
    '{ 16, 16,   0,  0, 0, 0, -32, -32},
    '{  5,  1,   0,  0, 0, 0,   3,   6},
    '{ -5,  1,   0,  0, 0, 0,   3,  -6},
    '{ 20, 12,  10,  6,-7, 9,  40,  11},
    '{ 24, 16,   0,  0, 0, 0,  16,  96},
    '{  0,  0,   0,  0, 0, 0,  16,   0},
    '{  0,  0, -24, 16, 0, 0, -16, -96},
    '{  0,  0,   3,  4, 5, 6,   8,   9},
    '{  1,  1,   0,  0, 0, 0,  -3,  -1}
  };

  logic clk = 1'b0, rst_n = 1'b0, vin = 1'b0;
  logic signed [15:0] ma = '0, mb = '0, sa = '0, sb = '0, aa = '0, ab = '0, dv = '0;
  logic out_valid, ovf;
  logic signed [7:0] coord;
  bit done = 1'b0;

  rat_coord_pipe uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vin),
    .mul_a_i(ma), .mul_b_i(mb), .sub_a_i(sa), .sub_b_i(sb),
    .add_a_i(aa), .add_b_i(ab), .div_i(dv),
    .out_valid_o(out_valid), .coord_o(coord), .ovf_o(ovf)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  bit sticky_m = 1'b0;
  int q_val[$], q_cyc[$], q_ovf[$];
  bit q_sat[$];
  real q_real[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int a, input int b, input int c, input int d, input int e,
                      input int f, input int g, input int exp_v, input bit use_model,
                      input string tag);
    longint s, q;
    bit sat;
    s = longint'(a) * b - longint'(c) * d + longint'(e) * f;
    if (g == 0) begin
      sat = 1'b1;
      q   = (s < 0) ? -LIM : LIM;
    end else begin
      q   = (s * 4) / g;
      sat = (q > LIM) || (q < -LIM);
      if (q > LIM) q = LIM;
      if (q < -LIM) q = -LIM;
    end
    sticky_m = sticky_m | sat;
    ma = 16'(a); mb = 16'(b); sa = 16'(c); sb = 16'(d); aa = 16'(e); ab = 16'(f); dv = 16'(g);
    vin = 1'b1;
    q_val.push_back(use_model ? int'(q) : exp_v);
    q_cyc.push_back(cyc);
    q_ovf.push_back(int'(sticky_m));
    q_sat.push_back(sat);
    q_real.push_back((g == 0) ? 0.0 : (real'(s) / 256.0) / (real'(g) / 16.0));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    vin = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // result monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_val.size() == 0) begin
        check(1'b0, "R1/R8 out_valid without a pending set", 1, 0);
      end else begin
        int ev, ec, eo;
        bit es;
        real er, diff;
        string t;
        ev = q_val.pop_front(); ec = q_cyc.pop_front(); eo = q_ovf.pop_front();
        es = q_sat.pop_front(); er = q_real.pop_front(); t = q_tag.pop_front();
        check(int'(coord) == ev, {t, " value"}, int'(coord), ev);
        check(cyc - ec == LAT, "R1 latency", cyc - ec, LAT);
        check(int'(ovf) == eo, {t, " R6 flag"}, int'(ovf), eo);
        if (!es) begin
          diff = real'(coord) / 64.0 - er;
          if (diff < 0.0) diff = -diff;
          check(diff < 0.0625, "R3 accuracy within 1/16 (x1000)", int'(diff * 1000.0), 62);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
    check(coord == 8'sd0, "R7 coord in reset", int'(coord), 0);
    check(ovf == 1'b0, "R7 ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: table back-to-back; rows 7 and 9 sit exactly on the R4 bound
    for (int i = 0; i < NV; i++)
      push(TV[i][0], TV[i][1], TV[i][2], TV[i][3], TV[i][4], TV[i][5], TV[i][6],
           TV[i][7], 1'b0, "R3 table");
    idle(LAT + 2);
    check(ovf == 1'b0, "R4 exact bound leaves flag clear", int'(ovf), 0);

    // R8: operands with in_valid low change nothing
    hold = int'(coord);
    for (int k = 0; k < 6; k++) begin
      ma = 16'(100 + k); mb = 16'(37); dv = 16'(k);
      @(negedge clk);
      check(int'(coord) == hold, "R8 coord held", int'(coord), hold);
      check(out_valid == 1'b0, "R8 no result while idle", int'(out_valid), 0);
    end

    // R4/R5/R6: clamps mixed into an unbroken stream
    push(16, 16, 0, 0, 0, 0, 16, 64, 1'b0, "R3 before clamp");
    push(97, 4, 0, 0, 0, 0, 16, 96, 1'b0, "R4 just above bound");
    push(20, 12, 10, 6, -7, 9, 40, 11, 1'b0, "R6 normal after clamp");
    push(-32, 32, 0, 0, 0, 0, 16, -96, 1'b0, "R4 negative clamp");
    push(1, 1, 0, 0, 0, 0, 0, 96, 1'b0, "R5 zero div positive");
    push(-1, 1, 0, 0, 0, 0, 0, -96, 1'b0, "R5 zero div negative");
    push(0, 0, 0, 0, 0, 0, 0, 96, 1'b0, "R5 zero div zero");
    push(2000, 2000, 0, 0, 0, 0, 1, 96, 1'b0, "R4 huge quotient");
    push(5, 1, 0, 0, 0, 0, 3, 6, 1'b0, "R6 normal at end");
    idle(LAT + 2);
    check(ovf == 1'b1, "R6 flag held while idle", int'(ovf), 1);

    // R2: random back-to-back stream
    for (int n = 0; n < 400; n++) begin
      int a, b, c, d, e, f, g;
      a = int'($urandom_range(0, 256)) - 128; b = int'($urandom_range(0, 256)) - 128;
      c = int'($urandom_range(0, 256)) - 128; d = int'($urandom_range(0, 256)) - 128;
      e = int'($urandom_range(0, 256)) - 128; f = int'($urandom_range(0, 256)) - 128;
      g = ($urandom_range(0, 31) == 0) ? 0 : int'($urandom_range(64, 4000));
      if ($urandom_range(0, 1) == 1) g = -g;
      push(a, b, c, d, e, f, g, 0, 1'b1, "R2 random stream");
    end
    idle(LAT + 2);
    check(q_val.size() == 0, "R2 all results delivered", q_val.size(), 0);

    // R7: reset clears the sticky flag
    rst_n = 1'b0;
    @(negedge clk);
    check(ovf == 1'b0, "R7 reset clears flag", int'(ovf), 0);
    check(out_valid == 1'b0, "R7 reset clears valid", int'(out_valid), 0);
    check(coord == 8'sd0, "R7 reset clears coord", int'(coord), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule